// File: doc/BRIEF.md
# Two-Strike Hiccup Overcurrent Protector

This block is the fault controller of a primary-side flyback switcher. It watches a per-cycle flag from the hard overcurrent comparator, which trips at 1 V on the sense resistor. That level sits above the 0.75 V level that ends each conduction period in normal operation. The comparator fires when the output rectifier or a winding is shorted, or when the transformer saturates. A single trip is treated as a possible disturbance: the converter keeps switching and the block only arms a warning. A trip in the switching cycle straight after the warning latches a shutdown.

Once latched, switching stops and the high-voltage start-up generator is held off. The supply capacitor therefore decays with no recharge. The latch is released in steps as the supply falls. First the undervoltage-lockout flag ends the latch. The generator stays off until the supply also drops below the restart level, near 5 V. The generator then recharges the supply, and switching resumes when the turn-on flag is seen. A brownout, meaning too little source current from the sense pin during on-time, enters the same shutdown and restart sequence directly.

Trip and brownout flags are synchronous to the clock and are sampled per switching cycle at a cycle-end strobe. The three supply comparator flags are asynchronous and pass a synchronizer. No data moves through this block, so it has no valid/ready interface; every pin is a plain level or strobe.

Top module: `hiccup_ocp_ctrl`

## Requirements
- R1: After reset, fault_state_o is 0 (idle), and sw_disable_o and hvgen_disable_o are both low.
- R2: A trip_i seen in any clock of a switching cycle is counted at that cycle's cyc_end_i strobe, including the strobe clock itself. Any number of trips within one cycle counts as one. A counted trip in idle moves fault_state_o to 1 (warning) in the clock after the strobe, and switching stays enabled.
- R3: In warning, a cycle whose strobe arrives with no counted trip returns fault_state_o to 0.
- R4: In warning, a cycle with a counted trip moves fault_state_o to 2 (latched) in the clock after the strobe. In that state sw_disable_o and hvgen_disable_o are both high.
- R5: In latched, both disables stay high until vcc_uvlo_i is seen. fault_state_o then moves to 3 (draining), with both disables still high.
- R6: In draining, seeing vcc_restart_i moves fault_state_o to 4 (recharging). In that state hvgen_disable_o is low and sw_disable_o stays high.
- R7: In recharging, seeing vcc_on_i moves fault_state_o to 0, and both disables go low.
- R8: A brownout_i flag counted in a cycle, by the same per-cycle rule as trips, moves the state from idle or warning straight to 2 (latched).
- R9: Each supply flag passes a SYNC_STAGES-deep synchronizer. A change therefore takes effect SYNC_STAGES+1 clocks after it is applied (3 clocks at the default of 2). A supply flag has no effect outside the state that waits for it; for example, vcc_uvlo_i in idle and vcc_restart_i in latched are ignored.
- R10: Trips and strobes that arrive while switching is disabled are discarded. They do not count toward the first cycle after the restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trip_i | input | 1 | 1 V overcurrent comparator flag, synchronous |
| brownout_i | input | 1 | Low on-time sense current flag, synchronous |
| cyc_end_i | input | 1 | One-clock strobe at the end of each switching cycle |
| vcc_uvlo_i | input | 1 | Supply below undervoltage-lockout level, asynchronous |
| vcc_restart_i | input | 1 | Supply below restart level, asynchronous |
| vcc_on_i | input | 1 | Supply above turn-on threshold, asynchronous |
| sw_disable_o | output | 1 | Holds the power switch off |
| hvgen_disable_o | output | 1 | Holds the start-up generator off |
| fault_state_o | output | 3 | 0 idle, 1 warning, 2 latched, 3 draining, 4 recharging |

## Verification
A wrong internal state shows up on fault_state_o and on the two disables one clock after the strobe or supply-flag sample that should have moved it. A lost trip, for example, leaves warning unreached at the next strobe. A stale trip latches one cycle too early. Errors in the release order show up as hvgen_disable_o dropping before the restart flag, or switching resuming before the turn-on flag. Both are visible within SYNC_STAGES+1 clocks of the flag change.

// File: rtl/hocp_pkg.sv
package hocp_pkg;
  localparam int unsigned ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE   = 3'd0,
    ST_WARN   = 3'd1,
    ST_LATCH  = 3'd2,
    ST_DRAIN  = 3'd3,
    ST_CHARGE = 3'd4
  } fault_st_e;
endpackage

// File: rtl/hocp_sync.sv
module hocp_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe[g] <= '0;
      end else begin
        if (g == 0) pipe[g] <= d_i;
        else        pipe[g] <= pipe[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/hocp_cyc_sampler.sv
module hocp_cyc_sampler #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm_i,
  input  logic         cyc_end_i,
  input  logic [N-1:0] flag_i,
  output logic         evt_o,
  output logic [N-1:0] seen_o
);
  logic [N-1:0] hit_q;

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         hit_q[g] <= 1'b0;
      else if (!arm_i)    hit_q[g] <= 1'b0;
      else if (cyc_end_i) hit_q[g] <= 1'b0;
      else if (flag_i[g]) hit_q[g] <= 1'b1;
    end
    assign seen_o[g] = hit_q[g] | flag_i[g];
  end

  assign evt_o = arm_i & cyc_end_i;
endmodule

// File: rtl/hocp_fsm.sv
module hocp_fsm
  import hocp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cyc_evt_i,
  input  logic      cyc_trip_i,
  input  logic      cyc_bo_i,
  input  logic      uvlo_s_i,
  input  logic      restart_s_i,
  input  logic      von_s_i,
  output fault_st_e state_o,
  output logic      sw_dis_o,
  output logic      gen_dis_o
);
  fault_st_e state_q, state_d;
  logic      sw_dis_q, gen_dis_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (cyc_evt_i) begin
        if (cyc_bo_i)        state_d = ST_LATCH;
        else if (cyc_trip_i) state_d = ST_WARN;
      end
      ST_WARN: if (cyc_evt_i) begin
        if (cyc_bo_i || cyc_trip_i) state_d = ST_LATCH;
        else                        state_d = ST_IDLE;
      end
      ST_LATCH:  if (uvlo_s_i)    state_d = ST_DRAIN;
      ST_DRAIN:  if (restart_s_i) state_d = ST_CHARGE;
      ST_CHARGE: if (von_s_i)     state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      sw_dis_q  <= 1'b0;
      gen_dis_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      sw_dis_q  <= (state_d == ST_LATCH) || (state_d == ST_DRAIN) || (state_d == ST_CHARGE);
      gen_dis_q <= (state_d == ST_LATCH) || (state_d == ST_DRAIN);
    end
  end

  assign state_o   = state_q;
  assign sw_dis_o  = sw_dis_q;
  assign gen_dis_o = gen_dis_q;
endmodule

// File: rtl/hiccup_ocp_ctrl.sv
module hiccup_ocp_ctrl
  import hocp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trip_i,
  input  logic            brownout_i,
  input  logic            cyc_end_i,
  input  logic            vcc_uvlo_i,
  input  logic            vcc_restart_i,
  input  logic            vcc_on_i,
  output logic            sw_disable_o,
  output logic            hvgen_disable_o,
  output logic [ST_W-1:0] fault_state_o
);
  localparam int unsigned N_SUP  = 3;
  localparam int unsigned N_CYCF = 2;

  logic [N_SUP-1:0]  sup_s;
  logic [N_CYCF-1:0] cyc_seen;
  logic              cyc_evt;
  logic              sw_dis;
  logic              gen_dis;
  fault_st_e         state;

  hocp_sync #(.W(N_SUP), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({vcc_on_i, vcc_restart_i, vcc_uvlo_i}),
    .q_o   (sup_s)
  );

  hocp_cyc_sampler #(.N(N_CYCF)) u_samp (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (~sw_dis),
    .cyc_end_i (cyc_end_i),
    .flag_i    ({brownout_i, trip_i}),
    .evt_o     (cyc_evt),
    .seen_o    (cyc_seen)
  );

  hocp_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_evt_i   (cyc_evt),
    .cyc_trip_i  (cyc_seen[0]),
    .cyc_bo_i    (cyc_seen[1]),
    .uvlo_s_i    (sup_s[0]),
    .restart_s_i (sup_s[1]),
    .von_s_i     (sup_s[2]),
    .state_o     (state),
    .sw_dis_o    (sw_dis),
    .gen_dis_o   (gen_dis)
  );

  assign sw_disable_o    = sw_dis;
  assign hvgen_disable_o = gen_dis;
  assign fault_state_o   = state;
endmodule

// File: rtl/hiccup_ocp_chk.sv
module hiccup_ocp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cyc_end_i,
  input logic       restart_s,
  input logic       von_s,
  input logic       sw_disable_o,
  input logic       hvgen_disable_o,
  input logic [2:0] fault_state_o
);
  p_state_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fault_state_o <= 3'd4);

  p_idle_one_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_state_o == 3'd0) |=> (fault_state_o <= 3'd2));

  p_latch_at_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_disable_o) |-> $past(cyc_end_i));

  p_gen_held_after_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_state_o == 3'd2) |=> hvgen_disable_o);

  p_gen_on_needs_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hvgen_disable_o) |-> $past(restart_s));

  p_charge_keeps_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_state_o == 3'd4) |-> (sw_disable_o && !hvgen_disable_o));

  p_resume_needs_von_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_disable_o) |-> ($past(von_s) && fault_state_o == 3'd0));
endmodule

bind hiccup_ocp_ctrl hiccup_ocp_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cyc_end_i       (cyc_end_i),
  .restart_s       (sup_s[1]),
  .von_s           (sup_s[2]),
  .sw_disable_o    (sw_disable_o),
  .hvgen_disable_o (hvgen_disable_o),
  .fault_state_o   (fault_state_o)
);

// File: tb/tb_hiccup_ocp_ctrl.sv
module tb_hiccup_ocp_ctrl;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trip = 1'b0, bo = 1'b0, cyc_end = 1'b0;
  logic uvlo = 1'b0, rstl = 1'b0, von = 1'b0;
  logic sw_dis, gen_dis;
  logic [2:0] st;

  int total = 0;
  int bad = 0;
  int model_st = 0;

  always #2.5 clk = ~clk;

  hiccup_ocp_ctrl #(.SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst_n(rst_n), .trip_i(trip), .brownout_i(bo),
    .cyc_end_i(cyc_end), .vcc_uvlo_i(uvlo), .vcc_restart_i(rstl),
    .vcc_on_i(von), .sw_disable_o(sw_dis), .hvgen_disable_o(gen_dis),
    .fault_state_o(st)
  );

  function automatic int next_st(input int s, input bit t, input bit b);
    if (s == 0) return b ? 2 : (t ? 1 : 0);
    if (s == 1) return (b || t) ? 2 : 0;
    return s;
  endfunction

  function automatic bit exp_sw(input int s);
    return s >= 2;
  endfunction

  function automatic bit exp_gen(input int s);
    return (s == 2) || (s == 3);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string req, input int s);
    check(req, st, s);
    check(req, sw_dis, exp_sw(s));
    check(req, gen_dis, exp_gen(s));
  endtask

  // Four-clock switching cycle; strobe on the last clock.
  task automatic run_cycle(input logic [3:0] tmask, input logic [3:0] bmask);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      trip = tmask[i];
      bo = bmask[i];
      cyc_end = (i == 3);
    end
    @(negedge clk);
    trip = 1'b0; bo = 1'b0; cyc_end = 1'b0;
  endtask

  task automatic settle();
    repeat (SYNC + 1) @(negedge clk);
  endtask

  task automatic release_seq();
    @(negedge clk); uvlo = 1'b1; von = 1'b0;
    settle(); check_all("R5", 3);
    @(negedge clk); rstl = 1'b1;
    settle(); check_all("R6", 4);
    @(negedge clk); rstl = 1'b0; uvlo = 1'b0; von = 1'b1;
    settle(); check_all("R7", 0);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog act=timeout exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd24680);
    repeat (3) @(negedge clk);
    check_all("R1", 0);
    rst_n = 1'b1;
    @(negedge clk);
    von = 1'b1;
    check_all("R1", 0);

    // R2: several trips in one cycle count once
    run_cycle(4'b1011, 4'b0000); check_all("R2", 1);
    // R3: clean cycle returns to idle
    run_cycle(4'b0000, 4'b0000); check_all("R3", 0);
    // R2: trip only at strobe clock
    run_cycle(4'b1000, 4'b0000); check_all("R2", 1);
    // R4: trip early in next cycle latches
    run_cycle(4'b0001, 4'b0000); check_all("R4", 2);

    // R9: restart flag while latched is ignored
    @(negedge clk); rstl = 1'b1;
    settle(); check_all("R9", 2);
    @(negedge clk); rstl = 1'b0;
    // R10: trips while disabled discarded
    run_cycle(4'b1111, 4'b0000); check_all("R10", 2);
    // R9: exact latency of uvlo
    @(negedge clk); uvlo = 1'b1; von = 1'b0;
    repeat (SYNC) @(negedge clk); check("R9", st, 2);
    @(negedge clk); check_all("R9", 3);
    @(negedge clk); rstl = 1'b1;
    settle(); check_all("R6", 4);
    run_cycle(4'b0111, 4'b0000); check_all("R10", 4);
    @(negedge clk); rstl = 1'b0; uvlo = 1'b0; von = 1'b1;
    settle(); check_all("R7", 0);
    run_cycle(4'b0000, 4'b0000); check_all("R10", 0);

    // R9: uvlo in idle ignored
    @(negedge clk); uvlo = 1'b1;
    settle(); check_all("R9", 0);
    @(negedge clk); uvlo = 1'b0;
    settle();

    // R8: brownout from idle and from warning
    run_cycle(4'b0000, 4'b0010); check_all("R8", 2);
    release_seq();
    run_cycle(4'b0100, 4'b0000); check_all("R2", 1);
    run_cycle(4'b0000, 4'b1000); check_all("R8", 2);
    release_seq();

    // Random cycles against the model
    model_st = 0;
    for (int n = 0; n < 400; n++) begin
      logic [3:0] tm, bm;
      tm = ($urandom_range(0, 9) < 6) ? 4'b0000 : 4'($urandom_range(1, 15));
      bm = ($urandom_range(0, 39) == 0) ? 4'($urandom_range(1, 15)) : 4'b0000;
      model_st = next_st(model_st, |tm, |bm);
      run_cycle(tm, bm);
      check_all((|bm) ? "R8" : "R2", model_st);
      if (model_st == 2) begin
        release_seq();
        model_st = 0;
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule